// File: doc/BRIEF.md
# Level-Wise Batch Tree Search Engine

This block looks up a batch of search keys in a multi-level B+ tree index that sits in an external memory. It does not walk each key from root to leaf on its own. It works breadth-first over the whole batch: every key is routed to its child pointer at the current level before any key is examined at the next level. A node fetched from memory stays in a local node register and serves every consecutive key that routes through it. When the batch arrives sorted by key, each distinct node on a level is therefore fetched exactly once.

Inside the loaded node, the search key is compared against all separator keys at the same time. A population count of the "separator ≤ key" results selects the child slot. At the leaf level an exact-match compare produces a found flag and the stored value. The host pulses `start`, streams in the keys, and then drains the results in input order. The results stream honours back-pressure. A one-cycle `done` pulse closes the batch.

The key stream (`s_*`) and the result stream (`r_*`) are valid/ready: a transfer happens on a clock edge where both are high. While `r_valid` is high and `r_ready` is low, the result holds steady. The key stream is only ready while a batch is being collected. The memory port is a plain read port with one request in flight at a time.

Top module: `tree_batch_search`

## Requirements
- R1: `start` is honoured only while `busy` is low. It opens collection, and `s_ready` is high only during collection. A `start` pulse while busy has no effect: `s_ready` stays low and the running batch completes unchanged.
- R2: A key accepted with `s_last` high closes the batch. Once MAX_BATCH keys have been accepted, the batch closes automatically whatever `s_last` is. After either event `s_ready` is low.
- R3: A node record on `mem_rsp_data` carries the following fields:
  - bits [CW-1:0]: the key count C, where CW = clog2(ORDER);
  - separator key j at bit offset CW + j·KEY_W, for j < ORDER-1;
  - pointer/value slot j at bit offset CW + (ORDER-1)·KEY_W + j·PTR_W, for j < ORDER.
  
  Key slots with j ≥ C are ignored whatever their contents.
- R4: At an inner level, a key follows pointer slot i, where i is the number of valid separators less than or equal to the key. A key equal to a separator therefore goes to the right-hand child.
- R5: With `depth` = D, the tree has D inner levels above the leaves, and root `root_ptr` is a leaf when D = 0. All keys are resolved at one level before any fetch for the next level.
- R6: A node is fetched only when a key's target pointer differs from the node currently loaded on that level. A sorted batch thus costs one fetch per distinct node per level. An unsorted batch refetches on every change of target.
- R7: At the leaf, a key equal to valid key j yields `r_found`=1 and `r_value` = slot j. Otherwise it yields `r_found`=0 and `r_value`=0.
- R8: Results come out one per accepted key, in acceptance order. They are held stable while `r_valid` is high and `r_ready` is low.
- R9: `done` is high for exactly the one cycle that follows the acceptance of the last result. In that same cycle `busy` is already low.
- R10: `mem_req_valid` is a one-cycle pulse carrying `mem_req_addr`. No new request is issued until `mem_rsp_valid` returns. The response may take any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new batch (taken when idle) |
| root_ptr | input | PTR_W | Address of the root node, sampled on start |
| depth | input | DEPTH_W | Number of inner levels above the leaves, sampled on start |
| busy | output | 1 | A batch is in progress |
| done | output | 1 | One-cycle pulse after the last result |
| s_valid | input | 1 | Search key valid |
| s_ready | output | 1 | Block accepts a key |
| s_key | input | KEY_W | Search key |
| s_last | input | 1 | Final key of the batch |
| mem_req_valid | output | 1 | Node read request pulse |
| mem_req_addr | output | PTR_W | Node address |
| mem_rsp_valid | input | 1 | Node data valid |
| mem_rsp_data | input | NODE_W | Node record |
| r_valid | output | 1 | Result valid |
| r_ready | input | 1 | Consumer accepts the result |
| r_found | output | 1 | Key present in the leaf |
| r_value | output | PTR_W | Value of the matching entry, 0 if absent |

## Verification
The bench builds the block with ORDER=4, 8-bit keys and pointers, MAX_BATCH=8 and a 3-bit depth. Nodes hold only three separators, so trees of depth 0, 1 and 2 can be built by hand. A batch of eight keys reaches the automatic batch close. Every unused key slot is left at zero, so a missing count mask would misroute keys. The exact sequence of fetched node addresses is compared for sorted and unsorted batches, which exposes both the level order and the reuse rule. Memory latency and result back-pressure are varied between scenarios.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  // Controller phases of one batch
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for start
    ST_LOAD,   // collecting search keys
    ST_STEP,   // resolving key idx at current level
    ST_WAIT,   // node fetch outstanding
    ST_EMIT    // streaming results out
  } tbs_state_e;
endpackage

// File: rtl/tbs_batch_ram.sv
module tbs_batch_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/tbs_node_decode.sv
module tbs_node_decode #(
  parameter int KEY_W = 16,
  parameter int PTR_W = 16,
  parameter int ORDER = 16,
  localparam int CNT_W  = $clog2(ORDER),
  localparam int KEYS   = ORDER - 1,
  localparam int NODE_W = CNT_W + KEYS*KEY_W + ORDER*PTR_W
) (
  input  logic [NODE_W-1:0] node,
  input  logic [KEY_W-1:0]  key,
  output logic [PTR_W-1:0]  child_ptr,
  output logic              hit,
  output logic [PTR_W-1:0]  hit_val
);
  localparam int KBASE = CNT_W;
  localparam int PBASE = CNT_W + KEYS*KEY_W;

  logic [CNT_W-1:0] cnt;
  logic [KEYS-1:0]  le_vec;
  logic [KEYS-1:0]  eq_vec;
  logic [PTR_W-1:0] slot [ORDER];
  logic [CNT_W-1:0] sel;

  assign cnt = node[CNT_W-1:0];

  // One comparator pair per separator, all in parallel
  for (genvar g = 0; g < KEYS; g++) begin : g_cmp
    logic [KEY_W-1:0] sep;
    logic             in_use;
    assign sep       = node[KBASE + g*KEY_W +: KEY_W];
    assign in_use    = (CNT_W'(g) < cnt);
    assign le_vec[g] = in_use && (sep <= key);
    assign eq_vec[g] = in_use && (sep == key);
  end

  for (genvar g = 0; g < ORDER; g++) begin : g_slot
    assign slot[g] = node[PBASE + g*PTR_W +: PTR_W];
  end

  // Child index is the population count of the compare vector
  always_comb begin
    sel = '0;
    for (int i = 0; i < KEYS; i++) sel = sel + CNT_W'(le_vec[i]);
  end

  assign child_ptr = slot[sel];

  always_comb begin
    hit     = 1'b0;
    hit_val = '0;
    for (int i = 0; i < KEYS; i++) begin
      if (eq_vec[i] && !hit) begin
        hit     = 1'b1;
        hit_val = slot[i];
      end
    end
  end
endmodule

// File: rtl/tree_batch_search.sv
module tree_batch_search
  import tbs_pkg::*;
#(
  parameter int KEY_W     = 16,
  parameter int PTR_W     = 16,
  parameter int ORDER     = 16,
  parameter int MAX_BATCH = 256,
  parameter int DEPTH_W   = 4,
  localparam int CNT_W  = $clog2(ORDER),
  localparam int NODE_W = CNT_W + (ORDER-1)*KEY_W + ORDER*PTR_W,
  localparam int IDX_W  = $clog2(MAX_BATCH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PTR_W-1:0]   root_ptr,
  input  logic [DEPTH_W-1:0] depth,
  output logic               busy,
  output logic               done,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [KEY_W-1:0]   s_key,
  input  logic               s_last,
  output logic               mem_req_valid,
  output logic [PTR_W-1:0]   mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [NODE_W-1:0]  mem_rsp_data,
  output logic               r_valid,
  input  logic               r_ready,
  output logic               r_found,
  output logic [PTR_W-1:0]   r_value
);
  tbs_state_e         state_q;
  logic [IDX_W-1:0]   idx_q, last_q;
  logic [DEPTH_W-1:0] lvl_q, depth_q;
  logic [PTR_W-1:0]   root_q, node_ptr_q, fetch_addr_q;
  logic [NODE_W-1:0]  node_q;
  logic               node_ok_q, req_q, done_q;

  logic [KEY_W-1:0] key_rd;
  logic [PTR_W-1:0] ptr_rd, ptr_wd, child_ptr, hit_val;
  logic             found_rd, hit;
  logic             take_key, node_match, step_go, at_leaf, ptr_we, found_we;

  assign take_key   = (state_q == ST_LOAD) && s_valid;
  assign node_match = node_ok_q && (node_ptr_q == ptr_rd);
  assign step_go    = (state_q == ST_STEP) && node_match;
  assign at_leaf    = (lvl_q == depth_q);
  assign ptr_we     = take_key || step_go;
  assign found_we   = step_go && at_leaf;

  always_comb begin
    if (take_key)     ptr_wd = root_q;
    else if (at_leaf) ptr_wd = hit ? hit_val : '0;
    else              ptr_wd = child_ptr;
  end

  // Per-key storage: search key, current pointer (value at the end), found flag
  tbs_batch_ram #(.W(KEY_W), .DEPTH(MAX_BATCH)) u_keys (
    .clk(clk), .we(take_key), .waddr(idx_q), .wdata(s_key),
    .raddr(idx_q), .rdata(key_rd)
  );

  tbs_batch_ram #(.W(PTR_W), .DEPTH(MAX_BATCH)) u_ptrs (
    .clk(clk), .we(ptr_we), .waddr(idx_q), .wdata(ptr_wd),
    .raddr(idx_q), .rdata(ptr_rd)
  );

  tbs_batch_ram #(.W(1), .DEPTH(MAX_BATCH)) u_found (
    .clk(clk), .we(found_we), .waddr(idx_q), .wdata(hit),
    .raddr(idx_q), .rdata(found_rd)
  );

  tbs_node_decode #(.KEY_W(KEY_W), .PTR_W(PTR_W), .ORDER(ORDER)) u_decode (
    .node(node_q), .key(key_rd), .child_ptr(child_ptr),
    .hit(hit), .hit_val(hit_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      last_q       <= '0;
      lvl_q        <= '0;
      depth_q      <= '0;
      root_q       <= '0;
      node_ptr_q   <= '0;
      fetch_addr_q <= '0;
      node_q       <= '0;
      node_ok_q    <= 1'b0;
      req_q        <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_LOAD;
            idx_q   <= '0;
            lvl_q   <= '0;
            root_q  <= root_ptr;
            depth_q <= depth;
          end
        end
        ST_LOAD: begin
          if (take_key) begin
            if (s_last || idx_q == IDX_W'(MAX_BATCH-1)) begin
              last_q    <= idx_q;
              idx_q     <= '0;
              node_ok_q <= 1'b0;
              state_q   <= ST_STEP;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_STEP: begin
          if (!node_match) begin
            req_q        <= 1'b1;
            fetch_addr_q <= ptr_rd;
            state_q      <= ST_WAIT;
          end else if (idx_q == last_q) begin
            idx_q <= '0;
            if (at_leaf) begin
              state_q <= ST_EMIT;
            end else begin
              lvl_q     <= lvl_q + 1'b1;
              node_ok_q <= 1'b0;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            node_q     <= mem_rsp_data;
            node_ptr_q <= fetch_addr_q;
            node_ok_q  <= 1'b1;
            state_q    <= ST_STEP;
          end
        end
        ST_EMIT: begin
          if (r_ready) begin
            if (idx_q == last_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign done          = done_q;
  assign s_ready       = (state_q == ST_LOAD);
  assign mem_req_valid = req_q;
  assign mem_req_addr  = fetch_addr_q;
  assign r_valid       = (state_q == ST_EMIT);
  assign r_found       = found_rd;
  assign r_value       = ptr_rd;
endmodule

// File: rtl/tbs_checker.sv
module tbs_checker #(
  parameter int PTR_W   = 16,
  parameter int DEPTH_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               s_valid,
  input logic               s_ready,
  input logic               s_last,
  input logic               mem_req_valid,
  input logic [PTR_W-1:0]   mem_req_addr,
  input logic               mem_rsp_valid,
  input logic               r_valid,
  input logic               r_ready,
  input logic               r_found,
  input logic [PTR_W-1:0]   r_value,
  input logic [DEPTH_W-1:0] lvl
);
  logic               pending_q;
  logic               prev_v_q;
  logic [PTR_W-1:0]   prev_addr_q;
  logic [DEPTH_W-1:0] prev_lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             pending_q <= 1'b0;
    else if (mem_req_valid) pending_q <= 1'b1;
    else if (mem_rsp_valid) pending_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) begin
      prev_v_q    <= 1'b0;
      prev_addr_q <= '0;
      prev_lvl_q  <= '0;
    end else if (mem_req_valid) begin
      prev_v_q    <= 1'b1;
      prev_addr_q <= mem_req_addr;
      prev_lvl_q  <= lvl;
    end
  end

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !pending_q);

  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_found) && $stable(r_value)));

  assert_phase_split_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (busy && !r_valid));

  assert_close_on_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last) |=> !s_ready);

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(r_valid && r_ready)));

  assert_level_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (lvl >= $past(lvl)));

  assert_node_reuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && prev_v_q && (lvl == prev_lvl_q)) |-> (mem_req_addr != prev_addr_q));
endmodule

bind tree_batch_search tbs_checker #(.PTR_W(PTR_W), .DEPTH_W(DEPTH_W)) u_tbs_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .r_valid(r_valid), .r_ready(r_ready),
  .r_found(r_found), .r_value(r_value), .lvl(lvl_q)
);

// File: tb/tree_batch_search_bench.sv
module tree_batch_search_bench;
  localparam int KW = 8, PW = 8, ORD = 4, MB = 8, DW = 3;
  localparam int NW = 2 + (ORD-1)*KW + ORD*PW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [PW-1:0] root_ptr = '0;
  logic [DW-1:0] depth = '0;
  logic busy, done, s_ready, mem_req_valid, r_valid, r_found;
  logic s_valid = 1'b0, s_last = 1'b0, r_ready = 1'b0;
  logic [KW-1:0] s_key = '0;
  logic [PW-1:0] mem_req_addr, r_value;
  logic mem_rsp_valid = 1'b0;
  logic [NW-1:0] mem_rsp_data = '0;

  always #4 clk = ~clk;

  tree_batch_search #(.KEY_W(KW), .PTR_W(PW), .ORDER(ORD), .MAX_BATCH(MB), .DEPTH_W(DW))
    u_tree_batch_search (
    .clk(clk), .rst_n(rst_n), .start(start), .root_ptr(root_ptr), .depth(depth),
    .busy(busy), .done(done), .s_valid(s_valid), .s_ready(s_ready), .s_key(s_key),
    .s_last(s_last), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .r_valid(r_valid),
    .r_ready(r_ready), .r_found(r_found), .r_value(r_value));

  // Memory model: node array, programmable latency, request log
  logic [NW-1:0] node_mem [0:63];
  int mem_lat = 0;
  int req_n = 0;
  int req_log [0:63];
  logic pend = 1'b0;
  logic [PW-1:0] pend_addr = '0;
  int lat_cnt = 0;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (lat_cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= node_mem[pend_addr[5:0]];
        pend          <= 1'b0;
      end else lat_cnt <= lat_cnt - 1;
    end
    if (mem_req_valid) begin
      pend                <= 1'b1;
      pend_addr           <= mem_req_addr;
      lat_cnt             <= mem_lat;
      req_log[req_n % 64] <= int'(mem_req_addr);
      req_n               <= req_n + 1;
    end
  end

  int n_chk = 0, n_bad = 0;
  int got_f [8], got_v [8];
  int fetch_base;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Unused key slots stay zero, so only the count can mask them (R3)
  function automatic logic [NW-1:0] mk(input int c, input int k0, input int k1, input int k2,
                                       input int p0, input int p1, input int p2, input int p3);
    logic [NW-1:0] n;
    n = '0;
    n[1:0] = 2'(c);
    n[2 +: 8] = 8'(k0);  n[10 +: 8] = 8'(k1); n[18 +: 8] = 8'(k2);
    n[26 +: 8] = 8'(p0); n[34 +: 8] = 8'(p1); n[42 +: 8] = 8'(p2); n[50 +: 8] = 8'(p3);
    return n;
  endfunction

  task automatic run_batch(input int keys [8], input int n, input bit use_last,
                           input int lat, input bit bp, input bit poke);
    int got, cyc, pf, pv;
    bit hold;
    mem_lat = lat;
    fetch_base = req_n;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < n; k++) begin
      s_valid = 1'b1;
      s_key   = 8'(keys[k]);
      s_last  = use_last && (k == n-1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
    chk(s_ready == 1'b0, "R2 ready low after batch close", int'(s_ready), 0);
    if (poke) begin
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(s_ready == 1'b0, "R1 start ignored while busy", int'(s_ready), 0);
    end
    got = 0; cyc = 0; hold = 1'b0; pf = 0; pv = 0;
    while (got < n && cyc < 3000) begin
      r_ready = bp ? (cyc % 3 != 1) : 1'b1;
      if (hold) begin
        chk(r_valid && int'(r_found) == pf && int'(r_value) == pv,
            "R8 result held under back-pressure", int'(r_value), pv);
      end
      if (r_valid) begin
        pf = int'(r_found); pv = int'(r_value);
        if (r_ready) begin
          got_f[got] = pf; got_v[got] = pv; got++;
        end
      end
      hold = r_valid && !r_ready;
      @(negedge clk);
      cyc++;
    end
    r_ready = 1'b0;
    chk(got == n, "R8 result count", got, n);
    chk(done == 1'b1 && busy == 1'b0, "R9 done pulse after last result", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R9 done lasts one cycle", int'(done), 0);
  endtask

  task automatic check_results(input int ef [8], input int ev [8], input int n, input string req);
    for (int k = 0; k < n; k++) begin
      chk(got_f[k] == ef[k], {req, " found flag"}, got_f[k], ef[k]);
      chk(got_v[k] == ev[k], {req, " value"}, got_v[k], ev[k]);
    end
  endtask

  task automatic check_fetch(input int es [8], input int m, input string req);
    chk(req_n - fetch_base == m, {req, " fetch count"}, req_n - fetch_base, m);
    for (int k = 0; k < m && k < req_n - fetch_base; k++)
      chk(req_log[(fetch_base + k) % 64] == es[k], {req, " fetch order"},
          req_log[(fetch_base + k) % 64], es[k]);
  endtask

  task automatic test_reset;
    chk(!busy && !s_ready && !r_valid && !mem_req_valid && !done,
        "R1 idle after reset", int'(busy), 0);
  endtask

  // Sorted batch, depth 1: reuse, equal-key routing, misses
  task automatic test_sorted_depth1;
    root_ptr = 8'd1; depth = 3'd1;
    run_batch('{5, 10, 20, 25, 40, 60, 61, 0}, 7, 1'b1, 0, 1'b0, 1'b0);
    check_results('{1, 1, 1, 0, 1, 1, 0, 0}, '{50, 51, 60, 0, 70, 72, 0, 0}, 7,
                  "R4 R7 R3 sorted depth1");
    check_fetch('{1, 10, 11, 12, 0, 0, 0, 0}, 4, "R6 R5 sorted depth1");
  endtask

  // Unsorted batch with slow memory and back-pressure
  task automatic test_unsorted;
    root_ptr = 8'd1; depth = 3'd1;
    run_batch('{40, 5, 41, 10, 0, 0, 0, 0}, 4, 1'b1, 3, 1'b1, 1'b0);
    check_results('{1, 1, 0, 1, 0, 0, 0, 0}, '{70, 50, 0, 51, 0, 0, 0, 0}, 4,
                  "R8 R10 unsorted order");
    check_fetch('{1, 12, 10, 12, 10, 0, 0, 0}, 5, "R6 refetch on change");
  endtask

  task automatic test_leaf_root;
    root_ptr = 8'd10; depth = 3'd0;
    run_batch('{15, 0, 0, 0, 0, 0, 0, 0}, 1, 1'b1, 1, 1'b0, 1'b0);
    check_results('{1, 0, 0, 0, 0, 0, 0, 0}, '{52, 0, 0, 0, 0, 0, 0, 0}, 1, "R5 depth0 R7");
    check_fetch('{10, 0, 0, 0, 0, 0, 0, 0}, 1, "R5 depth0");
  endtask

  task automatic test_depth2_busy_start;
    root_ptr = 8'd2; depth = 3'd2;
    run_batch('{10, 60, 100, 200, 250, 0, 0, 0}, 5, 1'b1, 2, 1'b1, 1'b1);
    check_results('{1, 1, 1, 1, 0, 0, 0, 0}, '{1, 4, 5, 7, 0, 0, 0, 0}, 5, "R4 R7 R1 depth2");
    check_fetch('{2, 3, 4, 20, 21, 22, 23, 0}, 7, "R5 level order depth2");
  endtask

  task automatic test_full_batch;
    root_ptr = 8'd1; depth = 3'd1;
    run_batch('{5, 10, 15, 20, 30, 40, 50, 60}, 8, 1'b0, 0, 1'b0, 1'b0);
    check_results('{1, 1, 1, 1, 1, 1, 1, 1}, '{50, 51, 52, 60, 61, 70, 71, 72}, 8,
                  "R2 full batch");
    check_fetch('{1, 10, 11, 12, 0, 0, 0, 0}, 4, "R6 full batch");
  endtask

  initial begin
    for (int a = 0; a < 64; a++) node_mem[a] = '0;
    node_mem[1]  = mk(2, 20, 40, 0, 10, 11, 12, 0);
    node_mem[10] = mk(3, 5, 10, 15, 50, 51, 52, 0);
    node_mem[11] = mk(2, 20, 30, 0, 60, 61, 0, 0);
    node_mem[12] = mk(3, 40, 50, 60, 70, 71, 72, 0);
    node_mem[2]  = mk(1, 100, 0, 0, 3, 4, 0, 0);
    node_mem[3]  = mk(1, 50, 0, 0, 20, 21, 0, 0);
    node_mem[4]  = mk(1, 150, 0, 0, 22, 23, 0, 0);
    node_mem[20] = mk(2, 10, 20, 0, 1, 2, 0, 0);
    node_mem[21] = mk(2, 50, 60, 0, 3, 4, 0, 0);
    node_mem[22] = mk(1, 100, 0, 0, 5, 0, 0, 0);
    node_mem[23] = mk(2, 150, 200, 0, 6, 7, 0, 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset;
    test_sorted_depth1;
    test_unsorted;
    test_leaf_root;
    test_depth2_busy_start;
    test_full_batch;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule